// File: doc/BRIEF.md
# PPS-Disciplined Sample Timestamper

This block gives every data sample that enters it an absolute time of arrival. It runs in the 10 MHz reference clock domain and keeps time as whole seconds plus a count of reference ticks inside the current second. A once-per-second pulse input realigns the sub-second count, and each pulse marks the start of a new second. A host processor that has decoded wall-clock time from the satellite receiver's serial messages writes a seconds value. That value is held until the next pulse and takes effect at it. After that the block keeps time without further host writes.

Samples arrive on a valid/ready stream. In the cycle a sample is accepted, the block captures the current seconds and tick values. It then presents the sample, its timestamp and a flag telling whether time had been loaded on a single-register output stream. Every sample gets exactly one timestamp, and the order of samples is kept. When no pulse arrives before the tick count reaches the end of the second, the block rolls over by itself and raises a holdover flag. The next pulse clears that flag.

Top module: `pps_stamper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, time_sec and time_tick are 0, and time_valid, holdover and m_valid are 0.
- R2: With no pulse and no rollover, time_tick increases by exactly one per clock and never leaves the range 0 to TICKS_PER_SEC-1.
- R3: A rising edge of pps_in first sampled at clock edge k sets time_tick to 0 at clock edge k+SYNC_STAGES. A pulse held high for many cycles counts as one edge.
- R4: At a pulse edge with no host value pending and no host write in that cycle, time_sec increases by one.
- R5: A host_load strobe stores host_sec as pending, and a later strobe overwrites it. At the next pulse edge time_sec takes the pending value. A strobe in the same cycle that the edge is applied takes effect at that edge.
- R6: time_valid is 0 until the first host value is applied at a pulse edge, and stays 1 from then until reset.
- R7: If time_tick is TICKS_PER_SEC-1 and no pulse edge is applied, the next clock sets time_tick to 0, increases time_sec by one and sets holdover. The next applied pulse edge clears holdover.
- R8: When a pulse edge is applied in the same cycle as a rollover would occur, time_sec changes once (a load or a single increment), time_tick becomes 0 and holdover is 0.
- R9: s_ready is high exactly when m_valid is low or m_ready is high. While m_valid is high and m_ready is low, m_valid stays high and m_data, m_stamp and m_time_ok do not change.
- R10: An accepted sample appears on the next clock with m_stamp = {seconds[31:0], tick[23:0]} (seconds in the upper bits). These are the time_sec and time_tick values of the accept cycle, before that clock's update. m_time_ok carries time_valid of the same cycle. Samples leave in order, once each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pps_in | input | 1 | Once-per-second pulse, asynchronous to clk |
| host_load | input | 1 | Strobe: store host_sec as the pending seconds value |
| host_sec | input | SEC_W (32) | Seconds value written by the host |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high together with s_valid |
| s_data | input | DATA_W (16) | Input sample |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream accepts the output sample |
| m_data | output | DATA_W (16) | Output sample |
| m_stamp | output | SEC_W+TICK_W (56) | Timestamp, seconds above ticks |
| m_time_ok | output | 1 | time_valid at the moment the sample was accepted |
| time_sec | output | SEC_W (32) | Current seconds |
| time_tick | output | TICK_W (24) | Current tick inside the second |
| time_valid | output | 1 | Host time has been applied |
| holdover | output | 1 | Last second ended by rollover without a pulse |

## Verification
Two pairs of events can land in the same cycle. A pulse edge can coincide with the self-timed rollover, and a host write can coincide with the pulse edge that applies it. The bench makes the first pair meet by driving pulses exactly one second-length apart after alignment. It makes the second pair meet by sweeping the host write over several cycle offsets around a pulse. A behavioural model in the bench decides the expected seconds, tick and holdover for each collision: the pulse wins over the rollover, and a same-cycle write is the value applied. The model's results are compared with the ports on every clock, while random sample traffic and backpressure check that stamps captured in those cycles carry the pre-update time.

// File: rtl/pps_stamper_pkg.sv
package pps_stamper_pkg;

   localparam int unsigned DEF_SEC_W   = 32;
   localparam int unsigned DEF_TICK_W  = 24;
   localparam int unsigned DEF_TPS     = 10_000_000;

   typedef enum logic [1:0] {
      TK_RUN   = 2'd0,
      TK_ALIGN = 2'd1,
      TK_WRAP  = 2'd2
   } tk_action_e;

endpackage

// File: rtl/pps_edge_detect.sv
module pps_edge_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pps_in,
   output logic pps_stb
);

   logic level;
   logic level_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign level = pps_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= pps_in;
               for (int i = 1; i < SYNC_STAGES; i++) begin
                  chain[i] <= chain[i-1];
               end
            end
         end
         assign level = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level;
   end

   assign pps_stb = level & ~level_q;

endmodule

// File: rtl/time_keeper.sv
module time_keeper
   import pps_stamper_pkg::*;
#(
   parameter int unsigned SEC_W         = DEF_SEC_W,
   parameter int unsigned TICK_W        = DEF_TICK_W,
   parameter int unsigned TICKS_PER_SEC = DEF_TPS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pps_stb,
   input  logic              host_load,
   input  logic [SEC_W-1:0]  host_sec,
   output logic [SEC_W-1:0]  sec,
   output logic [TICK_W-1:0] tick,
   output logic              time_valid,
   output logic              holdover
);

   localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_SEC - 1);

   logic             pend;
   logic [SEC_W-1:0] pend_sec;
   logic             load_now;
   logic [SEC_W-1:0] load_val;
   tk_action_e       action;

   assign load_now = host_load | pend;
   assign load_val = host_load ? host_sec : pend_sec;

   always_comb begin
      if (pps_stb)                action = TK_ALIGN;
      else if (tick == TICK_LAST) action = TK_WRAP;
      else                        action = TK_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec        <= '0;
         tick       <= '0;
         time_valid <= 1'b0;
         holdover   <= 1'b0;
         pend       <= 1'b0;
         pend_sec   <= '0;
      end else begin
         case (action)
            TK_ALIGN: begin
               tick     <= '0;
               holdover <= 1'b0;
               pend     <= 1'b0;
               if (load_now) begin
                  sec        <= load_val;
                  time_valid <= 1'b1;
               end else begin
                  sec <= sec + 1'b1;
               end
            end
            TK_WRAP: begin
               tick     <= '0;
               sec      <= sec + 1'b1;
               holdover <= 1'b1;
            end
            default: begin
               tick <= tick + 1'b1;
            end
         endcase
         if (!pps_stb && host_load) begin
            pend     <= 1'b1;
            pend_sec <= host_sec;
         end
      end
   end

endmodule

// File: rtl/stamp_stream.sv
module stamp_stream #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned STAMP_W = 56
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               s_valid,
   output logic               s_ready,
   input  logic [DATA_W-1:0]  s_data,
   input  logic [STAMP_W-1:0] stamp_in,
   input  logic               ok_in,
   output logic               m_valid,
   input  logic               m_ready,
   output logic [DATA_W-1:0]  m_data,
   output logic [STAMP_W-1:0] m_stamp,
   output logic               m_ok
);

   logic accept;

   assign s_ready = ~m_valid | m_ready;
   assign accept  = s_valid & s_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_data  <= '0;
         m_stamp <= '0;
         m_ok    <= 1'b0;
      end else if (accept) begin
         m_valid <= 1'b1;
         m_data  <= s_data;
         m_stamp <= stamp_in;
         m_ok    <= ok_in;
      end else if (m_ready) begin
         m_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/pps_stamper.sv
module pps_stamper
   import pps_stamper_pkg::*;
#(
   parameter int unsigned SEC_W         = DEF_SEC_W,
   parameter int unsigned TICK_W        = DEF_TICK_W,
   parameter int unsigned TICKS_PER_SEC = DEF_TPS,
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pps_in,
   input  logic                    host_load,
   input  logic [SEC_W-1:0]        host_sec,
   input  logic                    s_valid,
   output logic                    s_ready,
   input  logic [DATA_W-1:0]       s_data,
   output logic                    m_valid,
   input  logic                    m_ready,
   output logic [DATA_W-1:0]       m_data,
   output logic [SEC_W+TICK_W-1:0] m_stamp,
   output logic                    m_time_ok,
   output logic [SEC_W-1:0]        time_sec,
   output logic [TICK_W-1:0]       time_tick,
   output logic                    time_valid,
   output logic                    holdover
);

   localparam int unsigned STAMP_W = SEC_W + TICK_W;

   generate
      if (TICK_W < 1 || TICK_W > 31) begin : g_bad_tick_w
         $error("pps_stamper: TICK_W must be 1..31");
      end
      if (TICKS_PER_SEC < 2 || (TICKS_PER_SEC - 1) >= (1 << TICK_W)) begin : g_bad_tps
         $error("pps_stamper: TICKS_PER_SEC does not fit TICK_W");
      end
      if (SEC_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("pps_stamper: widths must be positive");
      end
   endgenerate

   logic pps_stb;

   pps_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .pps_in  (pps_in),
      .pps_stb (pps_stb)
   );

   time_keeper #(
      .SEC_W         (SEC_W),
      .TICK_W        (TICK_W),
      .TICKS_PER_SEC (TICKS_PER_SEC)
   ) u_time (
      .clk        (clk),
      .rst_n      (rst_n),
      .pps_stb    (pps_stb),
      .host_load  (host_load),
      .host_sec   (host_sec),
      .sec        (time_sec),
      .tick       (time_tick),
      .time_valid (time_valid),
      .holdover   (holdover)
   );

   stamp_stream #(.DATA_W(DATA_W), .STAMP_W(STAMP_W)) u_stream (
      .clk      (clk),
      .rst_n    (rst_n),
      .s_valid  (s_valid),
      .s_ready  (s_ready),
      .s_data   (s_data),
      .stamp_in ({time_sec, time_tick}),
      .ok_in    (time_valid),
      .m_valid  (m_valid),
      .m_ready  (m_ready),
      .m_data   (m_data),
      .m_stamp  (m_stamp),
      .m_ok     (m_time_ok)
   );

endmodule

// File: rtl/pps_stamper_chk.sv
module pps_stamper_chk #(
   parameter int unsigned SEC_W         = 32,
   parameter int unsigned TICK_W        = 24,
   parameter int unsigned TICKS_PER_SEC = 10_000_000,
   parameter int unsigned DATA_W        = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    pps_stb,
   input logic [TICK_W-1:0]       time_tick,
   input logic                    time_valid,
   input logic                    holdover,
   input logic                    m_valid,
   input logic                    m_ready,
   input logic [DATA_W-1:0]       m_data,
   input logic [SEC_W+TICK_W-1:0] m_stamp,
   input logic                    m_time_ok
);

   localparam logic [TICK_W-1:0] LAST = TICK_W'(TICKS_PER_SEC - 1);

   p_tick_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      time_tick <= LAST);

   p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pps_stb && time_tick != LAST) |=> time_tick == TICK_W'($past(time_tick) + 1'b1));

   p_pps_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pps_stb |=> time_tick == '0);

   p_valid_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      time_valid |=> time_valid);

   p_wrap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!pps_stb && time_tick == LAST) |=> (holdover && time_tick == '0));

   p_pps_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pps_stb |=> !holdover);

   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_stamp) && $stable(m_time_ok)));

endmodule

bind pps_stamper pps_stamper_chk #(
   .SEC_W         (SEC_W),
   .TICK_W        (TICK_W),
   .TICKS_PER_SEC (TICKS_PER_SEC),
   .DATA_W        (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pps_stb    (pps_stb),
   .time_tick  (time_tick),
   .time_valid (time_valid),
   .holdover   (holdover),
   .m_valid    (m_valid),
   .m_ready    (m_ready),
   .m_data     (m_data),
   .m_stamp    (m_stamp),
   .m_time_ok  (m_time_ok)
);

// File: tb/sim_pps_stamper.sv
`timescale 1ns/1ps
module sim_pps_stamper;

   localparam int SEC_W  = 32;
   localparam int TICK_W = 24;
   localparam int TPS    = 20;
   localparam int DATA_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pps_in = 1'b0;
   logic host_load = 1'b0;
   logic [SEC_W-1:0] host_sec = '0;
   logic s_valid = 1'b0;
   logic s_ready;
   logic [DATA_W-1:0] s_data = '0;
   logic m_valid;
   logic m_ready = 1'b0;
   logic [DATA_W-1:0] m_data;
   logic [SEC_W+TICK_W-1:0] m_stamp;
   logic m_time_ok;
   logic [SEC_W-1:0] time_sec;
   logic [TICK_W-1:0] time_tick;
   logic time_valid;
   logic holdover;

   always #5 clk = ~clk;

   pps_stamper #(
      .SEC_W(SEC_W), .TICK_W(TICK_W), .TICKS_PER_SEC(TPS), .DATA_W(DATA_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .host_load(host_load),
      .host_sec(host_sec), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_stamp(m_stamp),
      .m_time_ok(m_time_ok), .time_sec(time_sec), .time_tick(time_tick),
      .time_valid(time_valid), .holdover(holdover)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;
   bit traffic_on = 0;
   bit stall = 0;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   // behavioural reference model
   longint m_sec = 0, m_tick = 0, p_sec = 0;
   bit m_tv = 0, m_ho = 0, m_pend = 0;
   bit mo_v = 0, mo_ok = 0;
   longint mo_d = 0, mo_s = 0, mo_t = 0;
   bit [2:0] ph = '0;   // ph[0]=pps one edge ago, ph[1]=two, ph[2]=three

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sec = 0; m_tick = 0; p_sec = 0; m_tv = 0; m_ho = 0; m_pend = 0;
         mo_v = 0; mo_ok = 0; mo_d = 0; mo_s = 0; mo_t = 0; ph = '0;
      end else begin
         bit stb, acc;
         stb = ph[1] && !ph[2];
         ph = {ph[1:0], pps_in};
         acc = s_valid && (!mo_v || m_ready);
         if (acc) begin
            mo_d = s_data; mo_s = m_sec; mo_t = m_tick; mo_ok = m_tv; mo_v = 1;
         end else if (m_ready) begin
            mo_v = 0;
         end
         if (stb) begin
            m_tick = 0; m_ho = 0;
            if (host_load) begin m_sec = host_sec; m_tv = 1; end
            else if (m_pend) begin m_sec = p_sec; m_tv = 1; end
            else m_sec = (m_sec + 1) & 64'hFFFF_FFFF;
            m_pend = 0;
         end else begin
            if (m_tick == TPS - 1) begin
               m_tick = 0; m_sec = (m_sec + 1) & 64'hFFFF_FFFF; m_ho = 1;
            end else begin
               m_tick = m_tick + 1;
            end
            if (host_load) begin m_pend = 1; p_sec = host_sec; end
         end
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk("R2 R3 R7 R8 time_tick", 64'(time_tick), 64'(m_tick));
         chk("R4 R5 R7 R8 time_sec", 64'(time_sec), 64'(m_sec));
         chk("R6 time_valid", 64'(time_valid), 64'(m_tv));
         chk("R7 R8 holdover", 64'(holdover), 64'(m_ho));
         chk("R9 s_ready", 64'(s_ready), 64'(!mo_v || m_ready));
         chk("R9 m_valid", 64'(m_valid), 64'(mo_v));
         if (mo_v) begin
            chk("R10 m_data", 64'(m_data), 64'(mo_d));
            chk("R10 m_stamp", 64'(m_stamp), (64'(mo_s) << TICK_W) | 64'(mo_t));
            chk("R10 m_time_ok", 64'(m_time_ok), 64'(mo_ok));
         end
      end
   end

   // random sample traffic and backpressure
   always @(negedge clk) begin
      if (traffic_on) begin
         s_valid <= ($urandom_range(0, 9) < 7);
         s_data  <= DATA_W'($urandom);
         m_ready <= stall ? 1'b0 : ($urandom_range(0, 9) < 7);
      end
   end

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse(input int width);
      pps_in = 1'b1;
      cyc(width);
      pps_in = 1'b0;
   endtask

   task automatic load(input logic [SEC_W-1:0] v);
      host_sec = v; host_load = 1'b1;
      cyc(1);
      host_load = 1'b0;
   endtask

   initial begin
      cyc(3);
      // R1: reset state while reset held
      chk("R1 time_sec", 64'(time_sec), 0);
      chk("R1 time_tick", 64'(time_tick), 0);
      chk("R1 time_valid", 64'(time_valid), 0);
      chk("R1 holdover", 64'(holdover), 0);
      chk("R1 m_valid", 64'(m_valid), 0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 time_sec after release", 64'(time_sec), 0);
      traffic_on = 1;
      // R7: free run past several rollovers without a pulse
      cyc(50);
      // R3 R4: single pulse, no pending load
      pulse(1); cyc(9);
      // R5: two loads, second overwrites, applied at next pulse (R6)
      load(32'd1000); cyc(4);
      load(32'd2000); cyc(3);
      pulse(1); cyc(11);
      // R8: pulses exactly one second apart collide with rollover
      for (int k = 0; k < 6; k++) begin
         pulse(1); cyc(TPS - 1);
      end
      // R3: long high level counts as one edge
      pulse(12); cyc(30);
      // R5: host write swept around the applying edge
      for (int off = 0; off < 5; off++) begin
         pulse(1);
         cyc(off);
         load(32'd5000 + 32'(off));
         cyc(TPS + 7);
      end
      // R9: long stall holds output
      stall = 1; cyc(12); stall = 0; cyc(10);
      // R7: holdover again, then cleared
      cyc(45); pulse(1); cyc(8);
      traffic_on = 0;
      cyc(2);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         done = 1;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule